// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the control path of a single DMA channel. Software-side logic loads a channel setup: the pacing source, the chain target, the per-side increment enables, the transfer size, an optional address ring and its side, two start addresses and a transfer count. A trigger pulse then starts a run. For each transfer the sequencer offers a read address and a write address on a valid/ready handshake toward the data mover. Transfers are paced by one of the data request lines, one of the timer pulses, or by a permanent request.

After every accepted transfer the enabled addresses step forward by the transfer size. Either side, but not both, can be confined to a naturally aligned ring, so only its low bits move. When the count runs out the channel drops busy and emits a one-cycle chain pulse carrying the number of the channel to start next. A chain target equal to the channel's own number suppresses that pulse.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset busy, xfer_valid and chain_pulse are low, the start addresses and count are zero and the chain target equals CHAN_ID. A trigger issued before any setup write therefore produces no transfer and no chain pulse.
- R2: cfg_pace chooses the pacing source. Values 0 to 58 select dreq[n]. Values 59 to 62 select tmr_tick[0] to tmr_tick[3]. Value 63 is a request that is always present. Sources that are not selected have no effect.
- R3: xfer_valid is high only while busy and the selected source is high. A transfer is accepted in a cycle with xfer_valid and xfer_ready both high, and each accepted transfer lowers the remaining count by one.
- R4: cfg_size is 0 for a byte, 1 for a halfword and 2 for a word. An enabled address advances by 1, 2 or 4 after each accepted transfer. Code 3 steps by 4. xfer_size reports the code.
- R5: cfg_rd_inc and cfg_wr_inc each enable stepping for their own side. A side whose enable is clear presents its start address on every transfer.
- R6: A ring size n of 1 to 15 on the ringed side lets only address bits n-1:0 change, so the address wraps inside its aligned 2^n-byte block. A ring size of 0 gives no wrap.
- R7: cfg_ring_wr set to 0 applies the ring to the read address and set to 1 applies it to the write address. The other side steps linearly.
- R8: In the cycle after the final accepted transfer, busy is low and chain_pulse is high for one cycle with chain_id equal to the chain target. When the target equals CHAN_ID, no pulse is produced.
- R9: A trigger with a count of zero issues no transfer and leaves busy low. It still produces the chain pulse in the following cycle.
- R10: While busy, cfg_we and trig are ignored. The run continues with the setup it started with, and that setup stays stored for the next run.
- R11: A trigger in the cycle that carries a chain pulse starts a new run at once. That is the earliest cycle after completion in which a trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Store all setup inputs (ignored while busy) |
| cfg_pace | input | 6 | Pacing source select |
| cfg_chain | input | 4 | Channel to start on completion |
| cfg_ring_wr | input | 1 | Ring side: 0 read, 1 write |
| cfg_ring_bits | input | 4 | Ring size as address bit count, 0 = off |
| cfg_rd_inc | input | 1 | Read address stepping enable |
| cfg_wr_inc | input | 1 | Write address stepping enable |
| cfg_size | input | 2 | Transfer size code |
| cfg_rd_base | input | ADDR_W | Read start address |
| cfg_wr_base | input | ADDR_W | Write start address |
| cfg_count | input | CNT_W | Number of transfers |
| trig | input | 1 | Start a run (ignored while busy) |
| dreq | input | NUM_DREQ | Data request lines |
| tmr_tick | input | NUM_TMR | Timer pacing pulses |
| xfer_valid | output | 1 | Transfer offered |
| xfer_ready | input | 1 | Downstream accepts the offered transfer |
| xfer_rd_addr | output | ADDR_W | Read address of the offered transfer |
| xfer_wr_addr | output | ADDR_W | Write address of the offered transfer |
| xfer_size | output | 2 | Size code of the offered transfer |
| busy | output | 1 | Run in progress |
| chain_pulse | output | 1 | One-cycle completion trigger toward another channel |
| chain_id | output | 4 | Channel number carried by chain_pulse |

## Verification
Completion of one run and the start of the next can fall in the same cycle. While chain_pulse is high busy is already low, so a trigger raised in that cycle is accepted. The bench uses an unpaced four-transfer run with ready held high, so the final accept lands on a known edge. It raises trig exactly during the chain pulse and checks three things: the pulse is seen with busy low, busy is high one cycle later, and the scoreboard receives the second run's address pairs straight after the first with no lost or extra transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int PACE_W   = 6;
  localparam int TMR_BASE = 59;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xsize_e;

  typedef struct packed {
    logic [PACE_W-1:0] pace;
    logic [3:0]        chain;
    logic              ring_wr;
    logic [3:0]        ring_bits;
    logic              rd_inc;
    logic              wr_inc;
    xsize_e            size;
  } chan_cfg_t;

  function automatic logic [2:0] size_bytes(xsize_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_pace_sel.sv
module dma_pace_sel
  import dma_seq_pkg::*;
#(
  parameter int NUM_DREQ = 59,
  parameter int NUM_TMR  = 4
) (
  input  logic [NUM_DREQ-1:0] dreq,
  input  logic [NUM_TMR-1:0]  tmr_tick,
  input  logic [PACE_W-1:0]   sel,
  output logic                req
);

  localparam int NSRC = 1 << PACE_W;

  logic [NSRC-1:0] src;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == NSRC - 1) begin : g_perm
        assign src[i] = 1'b1;
      end else if (i >= TMR_BASE) begin : g_tmr
        if (i - TMR_BASE < NUM_TMR) begin : g_on
          assign src[i] = tmr_tick[i-TMR_BASE];
        end else begin : g_off
          assign src[i] = 1'b0;
        end
      end else if (i < NUM_DREQ) begin : g_dreq
        assign src[i] = dreq[i];
      end else begin : g_none
        assign src[i] = 1'b0;
      end
    end
  endgenerate

  assign req = src[sel];

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit WR_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic              inc,
  input  xsize_e            size,
  input  logic              ring_wr,
  input  logic [3:0]        ring_bits,
  output logic [ADDR_W-1:0] addr
);

  logic              ring_here;
  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    ring_here = (ring_wr == WR_SIDE) && (ring_bits != 4'd0);
    keep      = ring_here ? ~((ADDR_W'(1) << ring_bits) - ADDR_W'(1)) : '0;
    sum       = inc ? addr + ADDR_W'(size_bytes(size)) : addr;
    addr_en   = load || adv;
    addr_d    = load ? load_val : ((addr & keep) | (sum & ~keep));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (addr_en) begin
      addr <= addr_d;
    end
  end

  // R5
  inc_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !inc) |=> $stable(addr));

  // R6
  ring_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && ring_here) |=>
      ((addr >> $past(ring_bits)) == ($past(addr) >> $past(ring_bits))));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int NUM_DREQ = 59,
  parameter int NUM_TMR  = 4,
  parameter int CHAN_ID  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [5:0]          cfg_pace,
  input  logic [3:0]          cfg_chain,
  input  logic                cfg_ring_wr,
  input  logic [3:0]          cfg_ring_bits,
  input  logic                cfg_rd_inc,
  input  logic                cfg_wr_inc,
  input  logic [1:0]          cfg_size,
  input  logic [ADDR_W-1:0]   cfg_rd_base,
  input  logic [ADDR_W-1:0]   cfg_wr_base,
  input  logic [CNT_W-1:0]    cfg_count,
  input  logic                trig,
  input  logic [NUM_DREQ-1:0] dreq,
  input  logic [NUM_TMR-1:0]  tmr_tick,
  output logic                xfer_valid,
  input  logic                xfer_ready,
  output logic [ADDR_W-1:0]   xfer_rd_addr,
  output logic [ADDR_W-1:0]   xfer_wr_addr,
  output logic [1:0]          xfer_size,
  output logic                busy,
  output logic                chain_pulse,
  output logic [3:0]          chain_id
);

  localparam logic [3:0]       SELF    = 4'(CHAN_ID);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam chan_cfg_t        CFG_RST = '{pace: '0, chain: SELF, ring_wr: 1'b0,
                                           ring_bits: '0, rd_inc: 1'b0, wr_inc: 1'b0,
                                           size: SZ_BYTE};

  chan_cfg_t         cfg_q, cfg_d;
  logic [ADDR_W-1:0] rd_base_q, wr_base_q;
  logic [CNT_W-1:0]  count_q;
  logic              cfg_en;

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pulse_q, pulse_d;
  logic [3:0]        cid_q, cid_d;

  logic              req;
  logic              start;
  logic              acc;
  logic              chain_en;

  // setup store
  always_comb begin
    cfg_en = cfg_we && !busy_q;
    cfg_d  = '{pace: cfg_pace, chain: cfg_chain, ring_wr: cfg_ring_wr,
               ring_bits: cfg_ring_bits, rd_inc: cfg_rd_inc, wr_inc: cfg_wr_inc,
               size: xsize_e'(cfg_size)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RST;
      rd_base_q <= '0;
      wr_base_q <= '0;
      count_q   <= '0;
    end else if (cfg_en) begin
      cfg_q     <= cfg_d;
      rd_base_q <= cfg_rd_base;
      wr_base_q <= cfg_wr_base;
      count_q   <= cfg_count;
    end
  end

  dma_pace_sel #(
    .NUM_DREQ (NUM_DREQ),
    .NUM_TMR  (NUM_TMR)
  ) u_pace (
    .dreq     (dreq),
    .tmr_tick (tmr_tick),
    .sel      (cfg_q.pace),
    .req      (req)
  );

  // run control
  always_comb begin
    chain_en   = (cfg_q.chain != SELF);
    start      = trig && !busy_q;
    xfer_valid = busy_q && req;
    acc        = xfer_valid && xfer_ready;

    busy_d  = busy_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    cid_d   = cid_q;
    if (start) begin
      busy_d  = (count_q != '0);
      cnt_d   = count_q;
      pulse_d = (count_q == '0) && chain_en;
      cid_d   = cfg_q.chain;
    end else if (acc) begin
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        busy_d  = 1'b0;
        pulse_d = chain_en;
        cid_d   = cfg_q.chain;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      cid_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      cid_q   <= cid_d;
    end
  end

  dma_addr_step #(
    .ADDR_W    (ADDR_W),
    .WR_SIDE   (1'b0)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_val  (rd_base_q),
    .adv       (acc),
    .inc       (cfg_q.rd_inc),
    .size      (cfg_q.size),
    .ring_wr   (cfg_q.ring_wr),
    .ring_bits (cfg_q.ring_bits),
    .addr      (xfer_rd_addr)
  );

  dma_addr_step #(
    .ADDR_W    (ADDR_W),
    .WR_SIDE   (1'b1)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_val  (wr_base_q),
    .adv       (acc),
    .inc       (cfg_q.wr_inc),
    .size      (cfg_q.size),
    .ring_wr   (cfg_q.ring_wr),
    .ring_bits (cfg_q.ring_bits),
    .addr      (xfer_wr_addr)
  );

  assign xfer_size   = cfg_q.size;
  assign busy        = busy_q;
  assign chain_pulse = pulse_q;
  assign chain_id    = cid_q;

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cnt_q != CNT_ONE) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_ONE));

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(acc));

  // R8
  chain_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_pulse |-> (chain_id != SELF));

  // R9
  zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && count_q == '0 && chain_en) |=> (chain_pulse && !busy_q && !xfer_valid));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || $stable(cfg_q)));

endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  import dma_seq_pkg::*;

  localparam int ADDR_W   = 32;
  localparam int CNT_W    = 16;
  localparam int NUM_DREQ = 59;
  localparam int NUM_TMR  = 4;
  localparam int CHAN_ID  = 2;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                cfg_we;
  logic [5:0]          cfg_pace;
  logic [3:0]          cfg_chain;
  logic                cfg_ring_wr;
  logic [3:0]          cfg_ring_bits;
  logic                cfg_rd_inc, cfg_wr_inc;
  logic [1:0]          cfg_size;
  logic [ADDR_W-1:0]   cfg_rd_base, cfg_wr_base;
  logic [CNT_W-1:0]    cfg_count;
  logic                trig;
  logic [NUM_DREQ-1:0] dreq;
  logic [NUM_TMR-1:0]  tmr_tick;
  logic                xfer_valid, xfer_ready;
  logic [ADDR_W-1:0]   xfer_rd_addr, xfer_wr_addr;
  logic [1:0]          xfer_size;
  logic                busy, chain_pulse;
  logic [3:0]          chain_id;

  always #2 clk = ~clk;

  dma_chan_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_DREQ(NUM_DREQ), .NUM_TMR(NUM_TMR), .CHAN_ID(CHAN_ID)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pace(cfg_pace), .cfg_chain(cfg_chain),
    .cfg_ring_wr(cfg_ring_wr), .cfg_ring_bits(cfg_ring_bits), .cfg_rd_inc(cfg_rd_inc),
    .cfg_wr_inc(cfg_wr_inc), .cfg_size(cfg_size), .cfg_rd_base(cfg_rd_base),
    .cfg_wr_base(cfg_wr_base), .cfg_count(cfg_count), .trig(trig), .dreq(dreq),
    .tmr_tick(tmr_tick), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_rd_addr(xfer_rd_addr), .xfer_wr_addr(xfer_wr_addr), .xfer_size(xfer_size),
    .busy(busy), .chain_pulse(chain_pulse), .chain_id(chain_id)
  );

  typedef struct {
    logic [31:0] rd;
    logic [31:0] wr;
    logic [1:0]  sz;
    string       req;
  } exp_t;

  exp_t xq[$];
  int   cq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   rdy_mode = 0;
  bit   finished = 0;

  // bench-side copy of the stored setup
  int          m_chain, m_rbits, m_sz, m_cnt;
  bit          m_rwr, m_rinc, m_winc;
  logic [31:0] m_rbase, m_wbase;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] a, bit inc, bit ringed, int n, int sz);
    logic [31:0] s;
    logic [31:0] m;
    s = inc ? a + (32'd1 << sz) : a;
    if (ringed && n > 0) begin
      m = (32'd1 << n) - 32'd1;
      return (a & ~m) | (s & m);
    end
    return s;
  endfunction

  task automatic configure(input int pace, input int chain, input bit rwr, input int rbits,
                           input bit rinc, input bit winc, input int sz,
                           input logic [31:0] rbase, input logic [31:0] wbase, input int cnt);
    @(posedge clk); #1;
    cfg_pace = 6'(pace); cfg_chain = 4'(chain); cfg_ring_wr = rwr; cfg_ring_bits = 4'(rbits);
    cfg_rd_inc = rinc; cfg_wr_inc = winc; cfg_size = 2'(sz);
    cfg_rd_base = rbase; cfg_wr_base = wbase; cfg_count = CNT_W'(cnt); cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_chain = chain; m_rwr = rwr; m_rbits = rbits; m_rinc = rinc; m_winc = winc;
    m_sz = sz; m_rbase = rbase; m_wbase = wbase; m_cnt = cnt;
  endtask

  // driver: scoreboard entries for one run of the stored setup
  task automatic push_run(input string req);
    logic [31:0] a, w;
    exp_t e;
    a = m_rbase;
    w = m_wbase;
    for (int i = 0; i < m_cnt; i++) begin
      e.rd = a; e.wr = w; e.sz = 2'(m_sz); e.req = req;
      xq.push_back(e);
      a = nxt(a, m_rinc, !m_rwr, m_rbits, m_sz);
      w = nxt(w, m_winc, m_rwr, m_rbits, m_sz);
    end
    if (m_chain != CHAN_ID) cq.push_back(m_chain);
  endtask

  task automatic fire();
    @(posedge clk); #1 trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
  endtask

  task automatic wait_done();
    while (xq.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (xfer_valid && xfer_ready) begin
          if (xq.size() == 0) begin
            chk(1'b0, "R3", "unexpected transfer rd", xfer_rd_addr, 32'hx);
          end else begin
            exp_t e;
            e = xq.pop_front();
            chk(xfer_rd_addr == e.rd, e.req, "read address", xfer_rd_addr, e.rd);
            chk(xfer_wr_addr == e.wr, e.req, "write address", xfer_wr_addr, e.wr);
            chk(xfer_size == e.sz, "R4", "size code", 32'(xfer_size), 32'(e.sz));
          end
        end
        if (chain_pulse) begin
          if (cq.size() == 0) begin
            chk(1'b0, "R8", "unexpected chain pulse id", 32'(chain_id), 32'hx);
          end else begin
            int c;
            c = cq.pop_front();
            chk(chain_id == 4'(c), "R8", "chain id", 32'(chain_id), 32'(c));
          end
        end
      end
    end
  end

  // downstream ready pattern
  initial begin
    int cyc;
    cyc = 0;
    xfer_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (rdy_mode)
        0:       xfer_ready = 1'b1;
        1:       xfer_ready = cyc[0];
        default: xfer_ready = 1'b0;
      endcase
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_pace = '0; cfg_chain = '0; cfg_ring_wr = 1'b0;
    cfg_ring_bits = '0; cfg_rd_inc = 1'b0; cfg_wr_inc = 1'b0; cfg_size = '0;
    cfg_rd_base = '0; cfg_wr_base = '0; cfg_count = '0; trig = 1'b0; dreq = '0; tmr_tick = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state and default chain target
    @(negedge clk);
    chk(!busy, "R1", "busy after reset", 32'(busy), 0);
    chk(!xfer_valid, "R1", "valid after reset", 32'(xfer_valid), 0);
    chk(!chain_pulse, "R1", "chain after reset", 32'(chain_pulse), 0);
    fire();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy && !chain_pulse, "R1", "trigger before setup", 32'({busy, chain_pulse}), 0);
    end

    // R4 R5 R8: byte, both sides stepping, unpaced
    configure(63, 3, 0, 0, 1, 1, 0, 32'h100, 32'h200, 4);
    push_run("R4");
    fire();
    wait_done();
    chk(!busy, "R8", "busy after run", 32'(busy), 0);

    // R2 R5: halfword paced by dreq[5], write side fixed, ready alternating
    configure(5, CHAN_ID, 0, 0, 1, 0, 1, 32'h400, 32'h4000_0000, 3);
    push_run("R5");
    rdy_mode = 1;
    @(posedge clk); #1 dreq[6] = 1'b1;
    fire();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!xfer_valid, "R2", "unselected dreq line", 32'(xfer_valid), 0);
    end
    @(posedge clk); #1 dreq[6] = 1'b0; dreq[5] = 1'b1;
    wait_done();
    dreq = '0;
    rdy_mode = 0;

    // R6: word ring of 16 bytes on the read side; R7: write side linear
    configure(63, 7, 0, 4, 1, 1, 2, 32'h1008, 32'h2000, 6);
    push_run("R6");
    fire();
    wait_done();

    // R7: halfword ring of 8 bytes on the write side, read side linear
    configure(63, CHAN_ID, 1, 3, 1, 1, 1, 32'h5000, 32'h3006, 3);
    push_run("R7");
    fire();
    wait_done();

    // R2: timer 1 pacing, timer 0 has no effect
    configure(6'h3c, CHAN_ID, 0, 0, 1, 1, 0, 32'h10, 32'h20, 2);
    push_run("R2");
    fire();
    @(posedge clk); #1 tmr_tick = 4'b0001;
    @(negedge clk);
    chk(!xfer_valid, "R2", "timer 0 while timer 1 selected", 32'(xfer_valid), 0);
    @(posedge clk); #1 tmr_tick = 4'b0010;
    @(posedge clk); #1 tmr_tick = 4'b0000;
    repeat (2) @(negedge clk);
    chk(busy && !xfer_valid, "R3", "idle between timer pulses", 32'({busy, xfer_valid}), 32'b10);
    @(posedge clk); #1 tmr_tick = 4'b0010;
    @(posedge clk); #1 tmr_tick = 4'b0000;
    wait_done();

    // R2: highest data request line
    configure(6'h3a, CHAN_ID, 0, 0, 1, 1, 2, 32'h600, 32'h700, 1);
    push_run("R2");
    @(posedge clk); #1 dreq[58] = 1'b1;
    fire();
    wait_done();
    dreq = '0;

    // R9: zero count
    configure(63, 9, 0, 0, 1, 1, 0, 32'h0, 32'h0, 0);
    push_run("R9");
    fire();
    @(negedge clk);
    chk(!busy, "R9", "busy with zero count", 32'(busy), 0);
    chk(chain_pulse, "R9", "chain pulse with zero count", 32'(chain_pulse), 1);
    wait_done();

    // R10: setup write and trigger while busy are ignored
    configure(63, CHAN_ID, 0, 0, 1, 1, 2, 32'h800, 32'h900, 2);
    push_run("R10");
    rdy_mode = 2;
    fire();
    @(posedge clk); #1;
    cfg_rd_base = 32'hDEAD_0000; cfg_wr_base = 32'hBEEF_0000; cfg_count = 16'd9;
    cfg_size = 2'd0; cfg_chain = 4'd11; cfg_we = 1'b1;
    @(posedge clk); #1 cfg_we = 1'b0;
    fire();
    @(negedge clk);
    chk(busy, "R10", "still busy", 32'(busy), 1);
    chk(xfer_rd_addr == 32'h800, "R10", "read address held", xfer_rd_addr, 32'h800);
    rdy_mode = 0;
    wait_done();
    push_run("R10");
    fire();
    wait_done();

    // R11: trigger in the chain pulse cycle
    configure(63, 5, 0, 0, 1, 1, 0, 32'h40, 32'h80, 4);
    push_run("R11");
    push_run("R11");
    @(posedge clk); #1 trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
    repeat (4) @(posedge clk);
    #1 trig = 1'b1;
    @(negedge clk);
    chk(chain_pulse && !busy, "R11", "pulse with busy low", 32'({chain_pulse, busy}), 32'b10);
    @(posedge clk); #1 trig = 1'b0;
    @(negedge clk);
    chk(busy, "R11", "restarted", 32'(busy), 1);
    wait_done();

    chk(xq.size() == 0, "R3", "transfers left over", 32'(xq.size()), 0);
    chk(cq.size() == 0, "R8", "chain pulses left over", 32'(cq.size()), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule